// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned N-bit operands over N clock cycles and uses one adder of N bits. The multiplicand is held in its own register. A single shift register, one bit wider than the two operands together, joins an (N+1)-bit accumulator to the multiplier. The top bit of the accumulator catches the carry out of the adder. On each step the lowest multiplier bit decides whether the multiplicand is added into the low N bits of the accumulator. After that, accumulator and multiplier shift right together by one place.

The surrounding logic pulses the start input for one cycle, with the operands valid in that cycle. Busy stays high while the steps run. Done rises when the result is ready and stays high until the next operation starts. The product is read as the low N accumulator bits placed above the multiplier register.

Top module: `mul_shift_add`

## Requirements
- R1: After reset, busy_o and done_o are both 0.
- R2: A start_i sampled while busy_o is 0 loads both operands and clears the accumulator. busy_o is 1 from the next cycle on.
- R3: On a step where the lowest multiplier bit is 1, the multiplicand is added to the low N accumulator bits, and the carry out goes into the accumulator's top bit. Operands that produce carries, such as all-ones times all-ones, still give the exact product.
- R4: On a step where the lowest multiplier bit is 0, no addition is made. Each step ends by shifting the combined accumulator:multiplier register right by one bit, with a zero entering at the top.
- R5: Exactly N steps are made. done_o rises N cycles after the edge that samples start_i, busy_o is 1 for exactly those N cycles, and busy_o and done_o are never 1 together.
- R6: product_o, with the low N accumulator bits as its upper half and the multiplier register as its lower half, equals the unsigned product of the operands when done_o is 1. For N=4, 1110 × 1001 gives 01111110.
- R7: Without a new start, done_o stays 1 and product_o holds its value.
- R8: A start_i that arrives while busy_o is 1 is ignored. The operation in progress completes with its original operands and its original timing.
- R9: A start_i sampled while done_o is 1 begins a new operation at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a multiply |
| multiplicand_i | input | N | Multiplicand operand, sampled with start_i |
| multiplier_i | input | N | Multiplier operand, sampled with start_i |
| product_o | output | 2N | Unsigned product, valid while done_o is 1 |
| busy_o | output | 1 | High while add-and-shift steps run |
| done_o | output | 1 | High from completion until the next start |

## Verification
The bench builds the block with the default N=4. At that width all 256 operand pairs can be run exhaustively, so every carry pattern into the accumulator's top bit is covered, including 15×15 and the 1110×1001 case. Random operands from a fixed seed are then used to inject starts while the block is busy and to issue back-to-back starts from the done state. Cycle-exact checks on busy_o and done_o confirm the N-cycle latency and the hold behaviour.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        step_o = 1'b1;
        cnt_d  = cnt_q + CW'(1);
        if (cnt_q == LAST) state_d = ST_DONE;
      end
      default: begin
        // start ignored only while running
        if (start_i) begin
          load_o  = 1'b1;
          cnt_d   = '0;
          state_d = ST_RUN;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);

  p_busy_done_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_done_after_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cnt_q == LAST |=> done_o);
  p_done_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && cnt_q != LAST |=> busy_o && !done_o);
  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && start_i |=> busy_o);
endmodule

// File: rtl/mul_dp.sv
module mul_dp #(
  parameter int N = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic [2*N-1:0] product_o
);
  logic [N:0]   acc_q;
  logic [N-1:0] mc_q, mp_q;
  logic [N:0]   sum;

  // carry lands in acc bit N
  always_comb sum = mp_q[0] ? ({1'b0, acc_q[N-1:0]} + {1'b0, mc_q}) : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      mc_q  <= '0;
      mp_q  <= '0;
    end else if (load_i) begin
      acc_q <= '0;
      mc_q  <= mcand_i;
      mp_q  <= mplier_i;
    end else if (step_i) begin
      acc_q <= {1'b0, sum[N:1]};
      mp_q  <= {sum[0], mp_q[N-1:1]};
    end
  end

  assign product_o = {acc_q[N-1:0], mp_q};

  p_load_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> acc_q == '0 && mp_q == $past(mplier_i) && mc_q == $past(mcand_i));
  p_skip_add_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !mp_q[0] |=> acc_q == ($past(acc_q) >> 1));
  p_mcand_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> $stable(mc_q));
endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
  parameter int N = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   multiplicand_i,
  input  logic [N-1:0]   multiplier_i,
  output logic [2*N-1:0] product_o,
  output logic           busy_o,
  output logic           done_o
);
  logic load, step;

  mul_ctrl #(.N(N)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_dp #(.N(N)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .mcand_i  (multiplicand_i),
    .mplier_i (multiplier_i),
    .product_o(product_o)
  );

  p_product_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> $stable(product_o));
endmodule

// File: tb/mul_shift_add_tb.sv
`timescale 1ns/1ps
module mul_shift_add_tb;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] mc = '0, mp = '0;
  logic [2*N-1:0] prod;
  logic busy, done;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mul_shift_add #(.N(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .multiplicand_i(mc), .multiplier_i(mp),
    .product_o(prod), .busy_o(busy), .done_o(done)
  );

  function automatic logic [2*N-1:0] exp_prod(logic [N-1:0] a, logic [N-1:0] b);
    return (2*N)'(a) * (2*N)'(b);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // one operation; inj: inject a busy start mid-run; hold: extra idle cycles in done
  task automatic run_op(logic [N-1:0] a, logic [N-1:0] b, bit inj, int hold);
    logic [2*N-1:0] e;
    e = exp_prod(a, b);
    @(negedge clk);
    start = 1'b1; mc = a; mp = b;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R2", {busy, done}, 2'b10);
    for (int j = 1; j < N; j++) begin
      if (inj && j == 1) begin
        start = 1'b1; mc = N'($urandom); mp = N'($urandom);
      end
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1 && done == 1'b0, inj ? "R8" : "R5", {busy, done}, 2'b10);
    end
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R5", {busy, done}, 2'b01);
    chk(prod == e, inj ? "R8" : (b != '0 && a != '0 ? "R3" : "R6"), prod, e);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(done == 1'b1 && prod == e, "R7", prod, e);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    #20;
    chk(busy == 1'b0 && done == 1'b0, "R1", {busy, done}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", {busy, done}, 2'b00);
    // R6 directed example
    run_op(4'b1110, 4'b1001, 1'b0, 0);
    chk(prod == 8'b0111_1110, "R6", prod, 8'b0111_1110);
    // R3 full carry chain
    run_op(4'hF, 4'hF, 1'b0, 2);
    // R4 no-add steps only
    run_op(4'hD, 4'h0, 1'b0, 0);
    run_op(4'h0, 4'hF, 1'b0, 0);
    // exhaustive; R9 back-to-back from done
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_op(N'(a), N'(b), 1'b0, (a + b) % 3);
    // R8 random ignored starts
    for (int k = 0; k < 40; k++)
      run_op(N'($urandom), N'($urandom), 1'b1, 1);
    summary();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      summary();
    end
  end
endmodule